// File: doc/BRIEF.md
# SPI Loopback Test Front Panel

This block is the operator panel for a board-level loopback test in which a mode-0 SPI master (CPOL=0, CPHA=0) and a mode-0 SPI slave in the same design exchange 4-bit words over external wires. Three single-cycle button pulses, already debounced, drive it. They are a clear pulse, a mode pulse and an action pulse. The operator steps through four modes. In two of them the action button edits a staged transmit word, one for the slave and one for the master. In the other two it hands the staged word to the slave, or hands both words over and starts the master.

The block drives the transmit word and one-cycle load strobe of each shifter. It latches the word each shifter reports as received whenever that shifter's valid flag is high. It scans the four values onto a multiplexed four-digit seven-segment display, one digit per refresh tick. The active mode is marked by the decimal point of the digit whose index equals the mode number.

Top module: `spi_loop_panel`

## Requirements
- R1: Each mode pulse advances the mode by one, from 0 through 3 and then back to 0. The mode leaves reset at 0.
- R2: `dp` is high only while the digit whose index equals the current mode is selected. It is low for the other three digits.
- R3: In mode 0, an action pulse increments `slv_tx_word` by one modulo 16 (15 becomes 0). No load strobe follows.
- R4: In mode 1, an action pulse makes `slv_tx_load` high for exactly the one cycle after the pulse. `mst_tx_load` stays low and both staged words are unchanged.
- R5: In mode 2, an action pulse increments `mst_tx_word` by one modulo 16. No load strobe follows.
- R6: In mode 3, an action pulse taken while `mst_busy` is low makes both `slv_tx_load` and `mst_tx_load` high together for the one cycle after the pulse. While `mst_busy` is high, the pulse is ignored and neither strobe rises.
- R7: A received word is captured only in a cycle where its valid flag is high. A word presented with the flag low leaves the displayed value unchanged.
- R8: Digit 0 (`dig_en[0]`, rightmost) shows the slave transmit word, digit 1 the slave received word, digit 2 the master transmit word, and digit 3 the master received word. `seg` is active high with segment a in bit 0 through g in bit 6, using the usual hexadecimal shapes (for example 0 = 0x3F, 1 = 0x06, A = 0x77, F = 0x71).
- R9: `dig_en` is always one-hot. Selection starts at digit 0 after reset and advances by one digit, 0,1,2,3,0,..., every `SCAN_DIV` clock cycles.
- R10: A clear pulse sets the mode and all four values to 0 on the next edge. It takes priority over a mode pulse, an action pulse and a received-valid flag in the same cycle. A mode pulse takes priority over an action pulse, which is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_mode_p | input | 1 | Debounced mode button, one-cycle pulse |
| btn_act_p | input | 1 | Debounced action button, one-cycle pulse |
| btn_clr_p | input | 1 | Debounced clear button, one-cycle pulse |
| mst_busy | input | 1 | Master transfer in progress |
| mst_rx_word | input | 4 | Word received by the master |
| mst_rx_vld | input | 1 | Master received word is valid this cycle |
| slv_rx_word | input | 4 | Word received by the slave |
| slv_rx_vld | input | 1 | Slave received word is valid this cycle |
| mst_tx_word | output | 4 | Staged master transmit word |
| mst_tx_load | output | 1 | One-cycle load/start strobe to the master |
| slv_tx_word | output | 4 | Staged slave transmit word |
| slv_tx_load | output | 1 | One-cycle load strobe to the slave |
| dig_en | output | 4 | One-hot digit select, bit 0 rightmost |
| seg | output | 7 | Segments a..g in bits 0..6, active high |
| dp | output | 1 | Decimal point of the selected digit |

## Verification
A wrong mode register is visible only through the decimal point, so it appears at the ports within one full scan, which is four refresh ticks, and at once in the strobes that follow the next action pulse. A corrupted staged word shows on `slv_tx_word` or `mst_tx_word` on the next edge. A corrupted received word is visible only when its digit comes round in the scan. A lost or doubled load strobe shows one cycle after the action pulse. The busy gate in mode 3 and the priority among simultaneous pulses are the corners most likely to hide errors.

// File: rtl/spi_panel_pkg.sv
package spi_panel_pkg;

    localparam int WORD_W  = 4;
    localparam int NUM_DIG = 4;
    localparam int MODE_W  = $clog2(NUM_DIG);
    localparam int SEG_W   = 7;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_EDIT_SLV = mode_t'(0);
    localparam mode_t MODE_LOAD_SLV = mode_t'(1);
    localparam mode_t MODE_EDIT_MST = mode_t'(2);
    localparam mode_t MODE_RUN      = mode_t'(3);

    // segment a in bit 0 .. g in bit 6, active high
    function automatic logic [SEG_W-1:0] hex_segments(input word_t v);
        logic [SEG_W-1:0] s;
        case (v)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/panel_seq.sv
module panel_seq
    import spi_panel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  btn_mode_p,
    input  logic  btn_act_p,
    input  logic  btn_clr_p,
    input  logic  mst_busy,
    input  word_t slv_rx_word,
    input  logic  slv_rx_vld,
    input  word_t mst_rx_word,
    input  logic  mst_rx_vld,
    output mode_t mode,
    output word_t slv_tx,
    output word_t mst_tx,
    output word_t slv_rx,
    output word_t mst_rx,
    output logic  slv_ld,
    output logic  mst_ld
);

    typedef struct packed {
        mode_t mode;
        word_t slv_tx;
        word_t mst_tx;
        word_t slv_rx;
        word_t mst_rx;
        logic  slv_ld;
        logic  mst_ld;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.slv_ld = 1'b0;
        seq_d.mst_ld = 1'b0;

        if (slv_rx_vld) seq_d.slv_rx = slv_rx_word;
        if (mst_rx_vld) seq_d.mst_rx = mst_rx_word;

        if (btn_clr_p) begin
            seq_d.mode   = MODE_EDIT_SLV;
            seq_d.slv_tx = '0;
            seq_d.mst_tx = '0;
            seq_d.slv_rx = '0;
            seq_d.mst_rx = '0;
        end else if (btn_mode_p) begin
            seq_d.mode = seq_q.mode + mode_t'(1);
        end else if (btn_act_p) begin
            case (seq_q.mode)
                MODE_EDIT_SLV: seq_d.slv_tx = seq_q.slv_tx + word_t'(1);
                MODE_LOAD_SLV: seq_d.slv_ld = 1'b1;
                MODE_EDIT_MST: seq_d.mst_tx = seq_q.mst_tx + word_t'(1);
                default: begin
                    if (!mst_busy) begin
                        seq_d.slv_ld = 1'b1;
                        seq_d.mst_ld = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign mode   = seq_q.mode;
    assign slv_tx = seq_q.slv_tx;
    assign mst_tx = seq_q.mst_tx;
    assign slv_rx = seq_q.slv_rx;
    assign mst_rx = seq_q.mst_rx;
    assign slv_ld = seq_q.slv_ld;
    assign mst_ld = seq_q.mst_ld;

endmodule

// File: rtl/disp_scan.sv
module disp_scan
    import spi_panel_pkg::*;
#(
    parameter int SCAN_DIV = 62500
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  mode_t                          mode,
    input  logic [NUM_DIG-1:0][WORD_W-1:0] vals,
    output logic [NUM_DIG-1:0]             dig_en,
    output logic [SEG_W-1:0]               seg,
    output logic                           dp
);

    localparam int DIV_SAFE = (SCAN_DIV > 1) ? SCAN_DIV : 2;
    localparam int CNT_W    = $clog2(DIV_SAFE);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_SAFE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        mode_t            idx;
    } scan_t;

    scan_t scan_d, scan_q;

    always_comb begin
        scan_d = scan_q;
        if (scan_q.cnt == CNT_LAST) begin
            scan_d.cnt = '0;
            scan_d.idx = scan_q.idx + mode_t'(1);
        end else begin
            scan_d.cnt = scan_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
        assign dig_en[g] = (scan_q.idx == mode_t'(g));
    end

    assign seg = hex_segments(vals[scan_q.idx]);
    assign dp  = (scan_q.idx == mode);

endmodule

// File: rtl/spi_loop_panel.sv
module spi_loop_panel
    import spi_panel_pkg::*;
#(
    parameter int SCAN_DIV = 62500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_mode_p,
    input  logic       btn_act_p,
    input  logic       btn_clr_p,
    input  logic       mst_busy,
    input  logic [3:0] mst_rx_word,
    input  logic       mst_rx_vld,
    input  logic [3:0] slv_rx_word,
    input  logic       slv_rx_vld,
    output logic [3:0] mst_tx_word,
    output logic       mst_tx_load,
    output logic [3:0] slv_tx_word,
    output logic       slv_tx_load,
    output logic [3:0] dig_en,
    output logic [6:0] seg,
    output logic       dp
);

    mode_t cur_mode;
    word_t slv_rx_hold;
    word_t mst_rx_hold;
    logic [NUM_DIG-1:0][WORD_W-1:0] shown;

    panel_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_mode_p  (btn_mode_p),
        .btn_act_p   (btn_act_p),
        .btn_clr_p   (btn_clr_p),
        .mst_busy    (mst_busy),
        .slv_rx_word (slv_rx_word),
        .slv_rx_vld  (slv_rx_vld),
        .mst_rx_word (mst_rx_word),
        .mst_rx_vld  (mst_rx_vld),
        .mode        (cur_mode),
        .slv_tx      (slv_tx_word),
        .mst_tx      (mst_tx_word),
        .slv_rx      (slv_rx_hold),
        .mst_rx      (mst_rx_hold),
        .slv_ld      (slv_tx_load),
        .mst_ld      (mst_tx_load)
    );

    // digit order: 0 slave tx, 1 slave rx, 2 master tx, 3 master rx
    assign shown = {mst_rx_hold, mst_tx_word, slv_rx_hold, slv_tx_word};

    disp_scan #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (cur_mode),
        .vals   (shown),
        .dig_en (dig_en),
        .seg    (seg),
        .dp     (dp)
    );

endmodule

// File: rtl/spi_loop_panel_chk.sv
module spi_loop_panel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       btn_mode_p,
    input logic       btn_act_p,
    input logic       btn_clr_p,
    input logic       mst_busy,
    input logic       slv_rx_vld,
    input logic [3:0] mst_tx_word,
    input logic       mst_tx_load,
    input logic [3:0] slv_tx_word,
    input logic       slv_tx_load,
    input logic [3:0] dig_en,
    input logic       dp,
    input logic [1:0] cur_mode,
    input logic [3:0] slv_rx_hold
);

    // R2
    dp_marks_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp |-> (dig_en == (4'b0001 << cur_mode)));

    // R3
    slv_edit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(btn_act_p && !btn_mode_p && !btn_clr_p && cur_mode == 2'd0)
        |-> (slv_tx_word == $past(slv_tx_word) + 4'd1));

    // R4
    slv_load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_tx_load |-> $past(btn_act_p && !btn_mode_p && !btn_clr_p && cur_mode[0]));

    // R5
    mst_edit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(btn_act_p && !btn_mode_p && !btn_clr_p && cur_mode == 2'd2)
        |-> (mst_tx_word == $past(mst_tx_word) + 4'd1));

    // R6
    mst_start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_tx_load |-> (slv_tx_load && !$past(mst_busy)));

    // R7
    rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(slv_rx_vld) && !$past(btn_clr_p)) |-> $stable(slv_rx_hold));

    // R9
    digit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dig_en) == 1);

    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(btn_clr_p) |-> (slv_tx_word == 4'd0 && mst_tx_word == 4'd0 && cur_mode == 2'd0));

endmodule

bind spi_loop_panel spi_loop_panel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .btn_mode_p  (btn_mode_p),
    .btn_act_p   (btn_act_p),
    .btn_clr_p   (btn_clr_p),
    .mst_busy    (mst_busy),
    .slv_rx_vld  (slv_rx_vld),
    .mst_tx_word (mst_tx_word),
    .mst_tx_load (mst_tx_load),
    .slv_tx_word (slv_tx_word),
    .slv_tx_load (slv_tx_load),
    .dig_en      (dig_en),
    .dp          (dp),
    .cur_mode    (cur_mode),
    .slv_rx_hold (slv_rx_hold)
);

// File: tb/spi_loop_panel_bench.sv
module spi_loop_panel_bench;

    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_mode_p = 1'b0, btn_act_p = 1'b0, btn_clr_p = 1'b0, mst_busy = 1'b0;
    logic [3:0] mst_rx_word = '0, slv_rx_word = '0;
    logic       mst_rx_vld = 1'b0, slv_rx_vld = 1'b0;
    logic [3:0] mst_tx_word, slv_tx_word, dig_en;
    logic       mst_tx_load, slv_tx_load, dp;
    logic [6:0] seg;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model
    int m_mode = 0;
    logic [3:0] m_val [4];

    always #4 clk = ~clk;

    spi_loop_panel #(.SCAN_DIV(DIV)) u_spi_loop_panel (
        .clk(clk), .rst_n(rst_n), .btn_mode_p(btn_mode_p), .btn_act_p(btn_act_p),
        .btn_clr_p(btn_clr_p), .mst_busy(mst_busy), .mst_rx_word(mst_rx_word),
        .mst_rx_vld(mst_rx_vld), .slv_rx_word(slv_rx_word), .slv_rx_vld(slv_rx_vld),
        .mst_tx_word(mst_tx_word), .mst_tx_load(mst_tx_load), .slv_tx_word(slv_tx_word),
        .slv_tx_load(slv_tx_load), .dig_en(dig_en), .seg(seg), .dp(dp));

    function automatic logic [6:0] seg_ref(input logic [3:0] v);
        case (v)
            4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
            4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
            4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
            4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_words(input string tag);
        check({tag, " slv_tx_word"}, int'(slv_tx_word), int'(m_val[0]));
        check({tag, " mst_tx_word"}, int'(mst_tx_word), int'(m_val[2]));
    endtask

    // wait for digit d, then check its segments and decimal point (R8, R2, R9)
    task automatic check_digit(input int d);
        int waited = 0;
        while (dig_en != (4'b0001 << d) && waited < 4 * DIV + 4) begin
            @(negedge clk);
            waited++;
        end
        check($sformatf("R9 digit %0d selected", d), int'(dig_en), int'(4'b0001 << d));
        check($sformatf("R8 digit %0d segments", d), int'(seg), int'(seg_ref(m_val[d])));
        check($sformatf("R2 digit %0d dp", d), int'(dp), int'(d == m_mode));
    endtask

    task automatic press(input bit m, input bit a, input bit c, input bit busy);
        bit exp_sl = 1'b0;
        bit exp_ml = 1'b0;
        @(negedge clk);
        btn_mode_p = m; btn_act_p = a; btn_clr_p = c; mst_busy = busy;
        @(negedge clk);
        btn_mode_p = 1'b0; btn_act_p = 1'b0; btn_clr_p = 1'b0; mst_busy = 1'b0;
        if (c) begin
            m_mode = 0;
            foreach (m_val[i]) m_val[i] = 4'h0;
        end else if (m) begin
            m_mode = (m_mode + 1) % 4;
        end else if (a) begin
            case (m_mode)
                0: m_val[0] = m_val[0] + 4'd1;
                1: exp_sl = 1'b1;
                2: m_val[2] = m_val[2] + 4'd1;
                default: if (!busy) begin exp_sl = 1'b1; exp_ml = 1'b1; end
            endcase
        end
        check("R4/R6 slv_tx_load after press", int'(slv_tx_load), int'(exp_sl));
        check("R6 mst_tx_load after press", int'(mst_tx_load), int'(exp_ml));
        check_words("R3/R5/R10 after press");
        @(negedge clk);
        check("R4 slv_tx_load one cycle", int'(slv_tx_load), 0);
        check("R6 mst_tx_load one cycle", int'(mst_tx_load), 0);
    endtask

    task automatic rx_push(input bit master, input logic [3:0] w, input bit vld);
        @(negedge clk);
        if (master) begin mst_rx_word = w; mst_rx_vld = vld; end
        else        begin slv_rx_word = w; slv_rx_vld = vld; end
        @(negedge clk);
        mst_rx_vld = 1'b0; slv_rx_vld = 1'b0;
        if (vld) m_val[master ? 3 : 1] = w;
    endtask

    task automatic goto_mode(input int md);
        while (m_mode != md) press(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        foreach (m_val[i]) m_val[i] = 4'h0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R1 reset dig_en", int'(dig_en), 1);
        check("R1 reset dp (mode 0)", int'(dp), 1);
        check("R8 reset seg", int'(seg), int'(seg_ref(4'h0)));
        check_words("R10 reset");
        check("R4 reset slv load", int'(slv_tx_load), 0);

        // R9: advance every DIV cycles
        for (int k = 1; k < 6; k++) begin
            repeat (DIV) @(negedge clk);
            check("R9 scan order", int'(dig_en), int'(4'b0001 << (k % 4)));
        end

        // R3: slave edit wraps 15 -> 0
        for (int k = 0; k < 17; k++) press(1'b0, 1'b1, 1'b0, 1'b0);
        check("R3 slave word wrap", int'(slv_tx_word), 1);
        check_digit(0);

        // R1: full cycle of modes with dp
        for (int k = 0; k < 4; k++) begin
            press(1'b1, 1'b0, 1'b0, 1'b0);
            check_digit(m_mode);
            check_digit((m_mode + 1) % 4);
        end
        check("R1 mode wrapped to 0", m_mode, 0);

        // R4: load slave
        goto_mode(1);
        press(1'b0, 1'b1, 1'b0, 1'b0);
        // R5: master edit
        goto_mode(2);
        for (int k = 0; k < 18; k++) press(1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 master word wrap", int'(mst_tx_word), 2);
        check_digit(2);
        // R6: start, busy and idle
        goto_mode(3);
        press(1'b0, 1'b1, 1'b0, 1'b1);
        press(1'b0, 1'b1, 1'b0, 1'b0);

        // R10: mode and action together -> mode wins
        press(1'b1, 1'b1, 1'b0, 1'b0);
        check("R10 mode beats action", m_mode, 0);
        check_digit(0);

        // R7: capture and ignore
        rx_push(1'b0, 4'hA, 1'b1);
        rx_push(1'b1, 4'h5, 1'b1);
        rx_push(1'b0, 4'h3, 1'b0);
        rx_push(1'b1, 4'hC, 1'b0);
        check_digit(1);
        check_digit(3);

        // R10: clear with mode pulse and rx valid in same cycle
        goto_mode(2);
        @(negedge clk);
        slv_rx_word = 4'h7; slv_rx_vld = 1'b1;
        btn_clr_p = 1'b1; btn_mode_p = 1'b1;
        @(negedge clk);
        slv_rx_vld = 1'b0; btn_clr_p = 1'b0; btn_mode_p = 1'b0;
        m_mode = 0;
        foreach (m_val[i]) m_val[i] = 4'h0;
        check_words("R10 clear");
        for (int d = 0; d < 4; d++) check_digit(d);

        // constrained random
        for (int it = 0; it < 300; it++) begin
            int r = int'($urandom % 16);
            if (r < 3)       press(1'b1, 1'b0, 1'b0, 1'b0);
            else if (r < 9)  press(1'b0, 1'b1, 1'b0, 1'($urandom % 2));
            else if (r < 11) rx_push(1'b0, 4'($urandom), 1'b1);
            else if (r < 13) rx_push(1'b1, 4'($urandom), 1'b1);
            else if (r < 15) rx_push(1'($urandom % 2), 4'($urandom), 1'b0);
            else             press(1'($urandom % 2), 1'($urandom % 2), 1'b1, 1'b0);
            check_words("R3/R5 random");
            check_digit(int'($urandom % 4));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule